// File: doc/BRIEF.md
# Multi-Point Thermal Threshold Ladder

This block supervises three digitized temperature points of an HF heating applicator: the patient contact region, the applicator head and cable, and the power-stage heatsink. Each point runs as its own loop. On every sample strobe the loop compares the absolute temperature with a staged set of limits. It also forms a rate of rise from a short history of samples. The loop then moves through a graded response: soft derate, hard stop, and a cooldown lockout that ends only after a timed release window.

The three loops are merged into one derate level, one stop request and one lockout flag for the power controller. Rate of rise can only bring derating forward. Hysteresis and a minimum hold time stop the derate level from chattering around a limit. The heatsink loop has two derate steps and the other two loops have one.

Top module: `thermal_ladder`

## Requirements
- R1: Channel state changes only on a clock edge where `sample_i` is 1. Temperature changes while `sample_i` is 0 leave all outputs unchanged.
- R2: While `rst_ni` is low, and after it is released with no samples taken, `derate_o` is 0, `stop_o` is 0 and `lockout_o` is 0. A reset at any point returns the block to this state.
- R3: A channel's level rises on the strobe where its temperature is at or above its first derate limit (level 1). For the heatsink it also rises at or above the second limit (level 2). The new value shows on the outputs in the cycle after that strobe edge. `derate_o` is an unsigned count from 0 to 2.
- R4: Once WIN samples are held, a sample that exceeds the sample taken WIN strobes earlier by more than SLOPE_LIM forces that channel to at least level 1. A fast rise alone never raises `stop_o`.
- R5: A channel lowers its level by one step at most per strobe. It lowers only when all of these hold: the temperature is below the limit of its current level minus HYST, there is no fast rise, and HOLD strobes have passed since the last level change.
- R6: A sample at or above a channel's stop limit raises `stop_o`. That channel then reports its highest derate level.
- R7: The first strobe after a stop with the temperature below the stop limit enters lockout, with `stop_o` and `lockout_o` both 1. A sample at or above the stop limit during lockout returns the channel to stop, with its lockout cleared.
- R8: Lockout ends, with the channel level at 0, on the COOL-th consecutive sample below the release limit. A sample at or above the release limit restarts that count.
- R9: `derate_o` is the largest channel level, and `stop_o` and `lockout_o` are the OR of the channel flags. Each channel is judged only on its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe marking new temperature codes |
| skin_temp_i | input | DW | Contact-region temperature code |
| head_temp_i | input | DW | Applicator head/cable temperature code |
| sink_temp_i | input | DW | Heatsink temperature code |
| derate_o | output | 2 | Combined derate level, 0 to 2 |
| stop_o | output | 1 | Stop request from any channel |
| lockout_o | output | 1 | Cooldown lockout active on any channel |

## Verification
The assertions check several rules on every cycle. The channel state holds between strobes. The level drops by one step at most, and never before the hold time has run out. A fast rise with the temperature under the stop limit never leads to a stop. A lockout cannot end on a sample at or above the release limit. Lockout always comes with a stop request. Other behaviour can only be shown by the bench scenarios: where each limit sits, the exact strobe on which the level lowers, the two heatsink steps, the restart of the cooldown count, and how the three channels merge.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [1:0] {
    CH_RUN  = 2'd0,
    CH_STOP = 2'd1,
    CH_LOCK = 2'd2
  } ch_state_e;
endpackage

// File: rtl/tl_slope.sv
module tl_slope #(
  parameter int DW        = 12,
  parameter int WIN       = 4,
  parameter int SLOPE_LIM = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [DW-1:0] temp_i,
  output logic          fast_o
);
  localparam int FW = $clog2(WIN + 1);

  logic [DW-1:0] hist_q [WIN];
  logic [FW-1:0] fill_q;
  logic [DW-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hist_q[0] <= '0;
    else if (strobe_i)             hist_q[0] <= temp_i;
  end

  for (genvar i = 1; i < WIN; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 hist_q[i] <= '0;
      else if (strobe_i)           hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  fill_q <= '0;
    else if (strobe_i && fill_q != FW'(WIN))      fill_q <= fill_q + FW'(1);
  end

  // slope vs the sample WIN strobes back; falls are not of interest
  assign rise   = temp_i - hist_q[WIN-1];
  assign fast_o = (fill_q == FW'(WIN)) && (temp_i > hist_q[WIN-1]) &&
                  (rise > DW'(SLOPE_LIM));
endmodule

// File: rtl/tl_chan.sv
module tl_chan
  import tl_pkg::*;
#(
  parameter int DW        = 12,
  parameter int NUM_DER   = 1,
  parameter int D1        = 1600,
  parameter int D2        = 4095,
  parameter int T_STOP    = 1800,
  parameter int T_REL     = 1400,
  parameter int HYST      = 40,
  parameter int SLOPE_LIM = 60,
  parameter int WIN       = 4,
  parameter int HOLD      = 8,
  parameter int COOL      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [DW-1:0]    temp_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             stop_o,
  output logic             lock_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int CW = $clog2(COOL + 1);
  localparam logic [DW-1:0] D1_LO = DW'(D1 - HYST);
  localparam logic [DW-1:0] D2_LO = DW'(D2 - HYST);

  ch_state_e        st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [HW-1:0]    hold_q;
  logic [CW-1:0]    cool_q;

  logic             fast;
  logic             over1, over2, trip, below_rel, hold_done, lower_ok;
  logic [LVL_W-1:0] abs_lvl, tgt;

  tl_slope #(
    .DW        (DW),
    .WIN       (WIN),
    .SLOPE_LIM (SLOPE_LIM)
  ) u_slope (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .temp_i   (temp_i),
    .fast_o   (fast)
  );

  assign over1     = temp_i >= DW'(D1);
  assign over2     = (NUM_DER > 1) && (temp_i >= DW'(D2));
  assign trip      = temp_i >= DW'(T_STOP);
  assign below_rel = temp_i < DW'(T_REL);
  assign hold_done = hold_q == HW'(HOLD);

  always_comb begin
    abs_lvl = over2 ? LVL_W'(2) : (over1 ? LVL_W'(1) : LVL_W'(0));
    // rate of rise only pulls derating forward
    tgt     = (fast && abs_lvl == '0) ? LVL_W'(1) : abs_lvl;
    unique case (lvl_q)
      LVL_W'(2): lower_ok = !fast && (temp_i < D2_LO);
      LVL_W'(1): lower_ok = !fast && (temp_i < D1_LO);
      default:   lower_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_RUN;
      lvl_q  <= '0;
      hold_q <= '0;
      cool_q <= '0;
    end else if (strobe_i) begin
      unique case (st_q)
        CH_RUN: begin
          if (trip) begin
            st_q   <= CH_STOP;
            lvl_q  <= LVL_W'(NUM_DER);
            hold_q <= '0;
          end else if (tgt > lvl_q) begin
            lvl_q  <= tgt;
            hold_q <= '0;
          end else if (hold_done && lower_ok) begin
            lvl_q  <= lvl_q - LVL_W'(1);
            hold_q <= '0;
          end else if (!hold_done) begin
            hold_q <= hold_q + HW'(1);
          end
        end
        CH_STOP: begin
          if (!trip) begin
            st_q   <= CH_LOCK;
            cool_q <= '0;
          end
        end
        CH_LOCK: begin
          if (trip) begin
            st_q <= CH_STOP;
          end else if (!below_rel) begin
            cool_q <= '0;
          end else if (cool_q == CW'(COOL - 1)) begin
            st_q   <= CH_RUN;
            lvl_q  <= '0;
            hold_q <= '0;
            cool_q <= '0;
          end else begin
            cool_q <= cool_q + CW'(1);
          end
        end
        default: st_q <= CH_RUN;
      endcase
    end
  end

  assign lvl_o  = lvl_q;
  assign stop_o = st_q != CH_RUN;
  assign lock_o = st_q == CH_LOCK;

  assert_strobe_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(lvl_q) && $stable(st_q)));

  assert_slope_no_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_RUN && strobe_i && temp_i < DW'(T_STOP)) |=> !stop_o);

  assert_hold_before_lower_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_RUN && strobe_i && !hold_done) |=> (lvl_q >= $past(lvl_q)));

  assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_RUN && strobe_i) |=>
      ({1'b0, lvl_q} + 3'd1 >= {1'b0, $past(lvl_q)}));

  assert_no_early_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_LOCK && strobe_i && !below_rel) |=> (st_q != CH_RUN));
endmodule

// File: rtl/tl_merge.sv
module tl_merge
  import tl_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0][LVL_W-1:0] lvl_i,
  input  logic [NCH-1:0]            stop_i,
  input  logic [NCH-1:0]            lock_i,
  output logic [LVL_W-1:0]          lvl_o,
  output logic                      stop_o,
  output logic                      lock_o
);
  logic [NCH:0][LVL_W-1:0] run_max;

  assign run_max[0] = '0;
  for (genvar c = 0; c < NCH; c++) begin : g_max
    assign run_max[c+1] = (lvl_i[c] > run_max[c]) ? lvl_i[c] : run_max[c];
  end

  assign lvl_o  = run_max[NCH];
  assign stop_o = |stop_i;
  assign lock_o = |lock_i;
endmodule

// File: rtl/thermal_ladder.sv
module thermal_ladder
  import tl_pkg::*;
#(
  parameter int DW        = 12,
  parameter int SKIN_DER  = 1600,
  parameter int SKIN_STOP = 1800,
  parameter int SKIN_REL  = 1400,
  parameter int HEAD_DER  = 2000,
  parameter int HEAD_STOP = 2400,
  parameter int HEAD_REL  = 1800,
  parameter int SINK_DER1 = 2400,
  parameter int SINK_DER2 = 2800,
  parameter int SINK_STOP = 3200,
  parameter int SINK_REL  = 2200,
  parameter int HYST      = 40,
  parameter int SLOPE_LIM = 60,
  parameter int WIN       = 4,
  parameter int HOLD      = 8,
  parameter int COOL      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [DW-1:0]    skin_temp_i,
  input  logic [DW-1:0]    head_temp_i,
  input  logic [DW-1:0]    sink_temp_i,
  output logic [LVL_W-1:0] derate_o,
  output logic             stop_o,
  output logic             lockout_o
);
  localparam int NCH   = 3;
  localparam int NO_D2 = (1 << DW) - 1;

  logic [NCH-1:0][LVL_W-1:0] lvl;
  logic [NCH-1:0]            stp, lck;

  tl_chan #(
    .DW(DW), .NUM_DER(1), .D1(SKIN_DER), .D2(NO_D2), .T_STOP(SKIN_STOP),
    .T_REL(SKIN_REL), .HYST(HYST), .SLOPE_LIM(SLOPE_LIM), .WIN(WIN),
    .HOLD(HOLD), .COOL(COOL)
  ) u_skin (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(sample_i), .temp_i(skin_temp_i),
    .lvl_o(lvl[0]), .stop_o(stp[0]), .lock_o(lck[0])
  );

  tl_chan #(
    .DW(DW), .NUM_DER(1), .D1(HEAD_DER), .D2(NO_D2), .T_STOP(HEAD_STOP),
    .T_REL(HEAD_REL), .HYST(HYST), .SLOPE_LIM(SLOPE_LIM), .WIN(WIN),
    .HOLD(HOLD), .COOL(COOL)
  ) u_head (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(sample_i), .temp_i(head_temp_i),
    .lvl_o(lvl[1]), .stop_o(stp[1]), .lock_o(lck[1])
  );

  tl_chan #(
    .DW(DW), .NUM_DER(2), .D1(SINK_DER1), .D2(SINK_DER2), .T_STOP(SINK_STOP),
    .T_REL(SINK_REL), .HYST(HYST), .SLOPE_LIM(SLOPE_LIM), .WIN(WIN),
    .HOLD(HOLD), .COOL(COOL)
  ) u_sink (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(sample_i), .temp_i(sink_temp_i),
    .lvl_o(lvl[2]), .stop_o(stp[2]), .lock_o(lck[2])
  );

  tl_merge #(.NCH(NCH)) u_merge (
    .lvl_i  (lvl),
    .stop_i (stp),
    .lock_i (lck),
    .lvl_o  (derate_o),
    .stop_o (stop_o),
    .lock_o (lockout_o)
  );

  assert_lock_has_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> stop_o);

  assert_stop_full_derate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (derate_o != '0));
endmodule

// File: tb/sim_thermal_ladder.sv
`timescale 1ns/1ps
module sim_thermal_ladder;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sample_i = 1'b0;
  logic [DW-1:0] skin = '0, head = '0, sink = '0;
  logic [1:0]    derate_o;
  logic          stop_o, lockout_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thermal_ladder #(
    .DW(DW), .SKIN_DER(1600), .SKIN_STOP(1800), .SKIN_REL(1400),
    .HEAD_DER(2000), .HEAD_STOP(2400), .HEAD_REL(1800),
    .SINK_DER1(2400), .SINK_DER2(2800), .SINK_STOP(3200), .SINK_REL(2200),
    .HYST(40), .SLOPE_LIM(60), .WIN(4), .HOLD(3), .COOL(4)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i),
    .skin_temp_i(skin), .head_temp_i(head), .sink_temp_i(sink),
    .derate_o(derate_o), .stop_o(stop_o), .lockout_o(lockout_o)
  );

  // {req, skin, head, sink, derate, stop, lockout}
  localparam int NV = 41;
  localparam logic [43:0] VEC [NV] = '{
    {4'd3, 12'd1000, 12'd1000, 12'd1000, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd1000, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd1000, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd1000, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd2500, 2'd1, 1'b0, 1'b0}, // R3 sink step 1
    {4'd3, 12'd1000, 12'd1000, 12'd2900, 2'd2, 1'b0, 1'b0}, // R3 sink step 2
    {4'd5, 12'd1000, 12'd1000, 12'd2900, 2'd2, 1'b0, 1'b0},
    {4'd5, 12'd1000, 12'd1000, 12'd2900, 2'd2, 1'b0, 1'b0},
    {4'd5, 12'd1000, 12'd1000, 12'd2780, 2'd2, 1'b0, 1'b0}, // R5 inside hysteresis
    {4'd5, 12'd1000, 12'd1000, 12'd2700, 2'd1, 1'b0, 1'b0}, // R5 one step down
    {4'd5, 12'd1000, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0}, // R5 hold running
    {4'd5, 12'd1000, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd5, 12'd1000, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd5, 12'd1000, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0}, // R5 hold expired
    {4'd3, 12'd1000, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0},
    {4'd3, 12'd1000, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0},
    {4'd4, 12'd1100, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0}, // R4 slope only
    {4'd4, 12'd1100, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd4, 12'd1100, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd4, 12'd1100, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0}, // R4 still fast
    {4'd4, 12'd1100, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0}, // R4 slope cleared
    {4'd4, 12'd1790, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0}, // R4 big rise, no stop
    {4'd4, 12'd1790, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd4, 12'd1790, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd4, 12'd1790, 12'd1000, 12'd2300, 2'd1, 1'b0, 1'b0},
    {4'd6, 12'd1850, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b0}, // R6 skin stop
    {4'd7, 12'd1700, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1}, // R7 lockout
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1},
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1},
    {4'd8, 12'd1500, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1}, // R8 count restarts
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1},
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1},
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd1, 1'b1, 1'b1},
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0}, // R8 released
    {4'd8, 12'd1300, 12'd1000, 12'd2300, 2'd0, 1'b0, 1'b0},
    {4'd9, 12'd1300, 12'd2100, 12'd2300, 2'd1, 1'b0, 1'b0}, // R9 head only
    {4'd9, 12'd1300, 12'd2500, 12'd2300, 2'd1, 1'b1, 1'b0},
    {4'd9, 12'd1300, 12'd2500, 12'd3300, 2'd2, 1'b1, 1'b0}, // R9 max of levels
    {4'd9, 12'd1300, 12'd1700, 12'd3300, 2'd2, 1'b1, 1'b1}, // R9 OR of flags
    {4'd9, 12'd1300, 12'd1700, 12'd3300, 2'd2, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [1:0] el, input logic es, input logic ek);
    checks++;
    if (derate_o !== el || stop_o !== es || lockout_o !== ek) begin
      failures++;
      $display("FAIL %s: got derate=%0d stop=%0b lock=%0b, expected derate=%0d stop=%0b lock=%0b",
               req, derate_o, stop_o, lockout_o, el, es, ek);
    end
  endtask

  task automatic step(input logic [DW-1:0] s, input logic [DW-1:0] h, input logic [DW-1:0] k);
    @(negedge clk);
    skin = s; head = h; sink = k; sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 in reset", 2'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 after reset", 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][39:28], VEC[i][27:16], VEC[i][15:4]);
      check($sformatf("R%0d row %0d", VEC[i][43:40], i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R1: no strobe, inputs ignored
    @(negedge clk);
    skin = 12'd4000; head = 12'd4000; sink = 12'd100;
    repeat (8) @(negedge clk);
    check("R1 no strobe hold", 2'd2, 1'b1, 1'b1);

    // R2: reset from lockout
    do_reset();
    check("R2 reset from lockout", 2'd0, 1'b0, 1'b0);

    // R7: re-trip during lockout returns to stop
    step(12'd1850, 12'd1000, 12'd1000);
    check("R6 stop from cold", 2'd1, 1'b1, 1'b0);
    step(12'd1700, 12'd1000, 12'd1000);
    check("R7 enter lockout", 2'd1, 1'b1, 1'b1);
    step(12'd1900, 12'd1000, 12'd1000);
    check("R7 re-trip to stop", 2'd1, 1'b1, 1'b0);

    // R3: exactly at the first limit
    do_reset();
    step(12'd1000, 12'd2000, 12'd1000);
    check("R3 head at limit", 2'd1, 1'b0, 1'b0);
    step(12'd1000, 12'd1999, 12'd1000);
    check("R5 hold blocks lowering", 2'd1, 1'b0, 1'b0);

    finish_run();
  end
endmodule